// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of completed virtual-to-physical translations. It sits between a processor's address path and a page table walker. Each cycle a lookup may present a virtual address and the current address space identifier. When a stored translation matches, the physical address and its attributes are returned combinationally in the same cycle. When nothing matches, the block raises a walk request for that address. The walker later returns its result through a refill port, which writes one entry.

Each entry describes either a 1 MB section or a 4 KB page. It also carries a global flag and an address space identifier. Global entries serve every address space and hold operating-system mappings. Non-global entries serve only the identifier they were filled with. A maintenance port can invalidate every entry. It can instead invalidate only the non-global entries of one identifier, so a process switch leaves the kernel mappings resident.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses and raises a walk request.
- R2: A hit drives `lk_hit`, the physical address and the attribute fields (`lk_ap`, `lk_cb`, `lk_dom`) combinationally in the same cycle as the lookup. On a miss, or with `lk_valid` low, the address and attribute outputs are zero.
- R3: `walk_req` is high exactly when `lk_valid` is high and the lookup misses, and `walk_va` then equals `lk_va`. With `lk_valid` low, both `lk_hit` and `walk_req` are low.
- R4: A page entry (`rf_section`=0) compares VA[31:12] with its tag and yields PA = {frame[19:0], VA[11:0]}. A section entry (`rf_section`=1) compares only VA[31:20] with the top 12 tag bits and yields PA = {frame[19:8], VA[19:0]}.
- R5: A non-global entry hits only when `cur_asid` equals its stored identifier. A global entry hits for any `cur_asid`.
- R6: A refill writes the lowest-numbered invalid entry when one exists. In that case the replacement pointer does not move.
- R7: When every entry is valid, a refill replaces the entry at the replacement pointer and then advances the pointer by one, wrapping after entry N-1. The pointer starts at 0 after reset.
- R8: A full flush (`fl_all`=1) invalidates every entry before the next cycle.
- R9: A selective flush (`fl_asid_en`=1) invalidates only the non-global entries whose identifier equals `fl_asid`. It keeps global entries and the entries of other identifiers.
- R10: A refill in the same cycle as either flush is discarded: no entry is written and the pointer does not move.
- R11: When several valid entries match a lookup, the lowest-numbered one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present |
| lk_va | input | 32 | Lookup virtual address |
| cur_asid | input | 8 | Current address space identifier |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_pa | output | 32 | Translated physical address |
| lk_ap | output | 2 | Access permission of hit entry |
| lk_cb | output | 2 | Cacheable/bufferable bits of hit entry |
| lk_dom | output | 4 | Domain of hit entry |
| walk_req | output | 1 | Miss: table walk needed |
| walk_va | output | 32 | Address to walk |
| rf_valid | input | 1 | Refill present |
| rf_vpn | input | 20 | Refill virtual page number VA[31:12] |
| rf_pfn | input | 20 | Refill physical frame number PA[31:12] |
| rf_section | input | 1 | Refill describes a 1 MB section |
| rf_global | input | 1 | Refill is global |
| rf_asid | input | 8 | Refill address space identifier |
| rf_ap | input | 2 | Refill access permission |
| rf_cb | input | 2 | Refill cacheable/bufferable bits |
| rf_dom | input | 4 | Refill domain |
| fl_all | input | 1 | Invalidate all entries |
| fl_asid_en | input | 1 | Invalidate non-global entries of one identifier |
| fl_asid | input | 8 | Identifier for selective invalidate |

## Verification
A wrong valid bit, tag, identifier or global flag shows up on the very next lookup of the affected address. It appears as a hit where a walk is expected, or the reverse, in the same cycle the lookup is presented. A replacement pointer that drifts only becomes visible later: the entry it evicted wrongly misses on a subsequent lookup. For that reason the bench keeps the table full for long stretches and looks up addresses from a small pool, so each eviction is probed within a few cycles.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef struct packed {
    logic [1:0] ap;
    logic [1:0] cb;
    logic [3:0] dom;
  } tlb_attr_t;

  typedef enum logic {
    SZ_PAGE    = 1'b0,
    SZ_SECTION = 1'b1
  } tlb_size_e;
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int SEC_W  = 12,
  parameter int ASID_W = 8
) (
  input  logic              ent_valid,
  input  tlb_size_e         ent_size,
  input  logic              ent_global,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]  ent_tag,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              match
);
  logic tag_eq;
  logic asid_ok;

  always_comb begin
    if (ent_size == SZ_SECTION)
      tag_eq = (ent_tag[VPN_W-1 -: SEC_W] == lk_vpn[VPN_W-1 -: SEC_W]);
    else
      tag_eq = (ent_tag == lk_vpn);
    asid_ok = ent_global || (ent_asid == cur_asid);
    match   = lk_valid && ent_valid && tag_eq && asid_ok;
  end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             commit,
  output logic [IDX_W-1:0] victim,
  output logic             all_valid
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    all_valid = &valid;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IDX_W'(i);
    victim = all_valid ? rr_q : free_idx;
    rr_d   = rr_q;
    if (commit && all_valid)
      rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (commit && all_valid)
      rr_q <= rr_d;
  end

  // R6: a free slot is never a valid one
  a_r6_victim_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    !all_valid |-> !valid[victim]);
  // R7: pointer steps by one on a full-table replacement
  a_r7_rr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && all_valid) |=>
      (rr_q == (($past(rr_q) == IDX_W'(N - 1)) ? '0 : $past(rr_q) + 1'b1)));
  // R6: pointer holds while a free slot is used
  a_r6_rr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && all_valid) |=> $stable(rr_q));
endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N          = 8,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int SECT_SHIFT = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [VA_W-1:0]            lk_va,
  input  logic [ASID_W-1:0]          cur_asid,
  output logic                       lk_hit,
  output logic [PA_W-1:0]            lk_pa,
  output logic [1:0]                 lk_ap,
  output logic [1:0]                 lk_cb,
  output logic [3:0]                 lk_dom,
  output logic                       walk_req,
  output logic [VA_W-1:0]            walk_va,
  input  logic                       rf_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0] rf_vpn,
  input  logic [PA_W-PAGE_SHIFT-1:0] rf_pfn,
  input  logic                       rf_section,
  input  logic                       rf_global,
  input  logic [ASID_W-1:0]          rf_asid,
  input  logic [1:0]                 rf_ap,
  input  logic [1:0]                 rf_cb,
  input  logic [3:0]                 rf_dom,
  input  logic                       fl_all,
  input  logic                       fl_asid_en,
  input  logic [ASID_W-1:0]          fl_asid
);
  localparam int VPN_W  = VA_W - PAGE_SHIFT;
  localparam int PFN_W  = PA_W - PAGE_SHIFT;
  localparam int SEC_W  = VA_W - SECT_SHIFT;
  localparam int PSEC_W = PA_W - SECT_SHIFT;
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;

  // entry storage
  logic [N-1:0]      valid_q, valid_d;
  logic [N-1:0]      glob_q;
  tlb_size_e         size_q [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [VPN_W-1:0]  tag_q  [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  tlb_attr_t         attr_q [N];

  logic [N-1:0]      match;
  logic [IDX_W-1:0]  hit_idx;
  logic              any_hit;
  logic              flushing;
  logic              commit;
  logic [IDX_W-1:0]  victim;
  logic              all_valid;
  logic [N-1:0]      wr_en;

  // per-entry compare
  for (genvar g = 0; g < N; g++) begin : g_cmp
    tlb_match #(.VPN_W(VPN_W), .SEC_W(SEC_W), .ASID_W(ASID_W)) cmp_i (
      .ent_valid (valid_q[g]),
      .ent_size  (size_q[g]),
      .ent_global(glob_q[g]),
      .ent_asid  (asid_q[g]),
      .ent_tag   (tag_q[g]),
      .lk_valid  (lk_valid),
      .lk_vpn    (lk_va[VA_W-1:PAGE_SHIFT]),
      .cur_asid  (cur_asid),
      .match     (match[g])
    );
  end

  // lowest index wins
  always_comb begin
    any_hit = |match;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  // lookup result
  always_comb begin
    lk_hit   = any_hit;
    walk_req = lk_valid && !any_hit;
    walk_va  = walk_req ? lk_va : '0;
    lk_pa    = '0;
    lk_ap    = '0;
    lk_cb    = '0;
    lk_dom   = '0;
    if (any_hit) begin
      if (size_q[hit_idx] == SZ_SECTION)
        lk_pa = {pfn_q[hit_idx][PFN_W-1 -: PSEC_W], lk_va[SECT_SHIFT-1:0]};
      else
        lk_pa = {pfn_q[hit_idx], lk_va[PAGE_SHIFT-1:0]};
      lk_ap  = attr_q[hit_idx].ap;
      lk_cb  = attr_q[hit_idx].cb;
      lk_dom = attr_q[hit_idx].dom;
    end
  end

  // replacement choice
  assign flushing = fl_all || fl_asid_en;
  assign commit   = rf_valid && !flushing;

  tlb_victim #(.N(N), .IDX_W(IDX_W)) vic_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid_q),
    .commit   (commit),
    .victim   (victim),
    .all_valid(all_valid)
  );

  // next state of valid bits and write enables
  always_comb begin
    valid_d = valid_q;
    wr_en   = '0;
    if (fl_all) begin
      valid_d = '0;
    end else if (fl_asid_en) begin
      for (int i = 0; i < N; i++)
        if (!glob_q[i] && (asid_q[i] == fl_asid)) valid_d[i] = 1'b0;
    end else if (rf_valid) begin
      wr_en[victim]   = 1'b1;
      valid_d[victim] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else
      valid_q <= valid_d;
  end

  // payload registers, enabled per entry
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        glob_q[g] <= 1'b0;
        size_q[g] <= SZ_PAGE;
        asid_q[g] <= '0;
        tag_q[g]  <= '0;
        pfn_q[g]  <= '0;
        attr_q[g] <= '0;
      end else if (wr_en[g]) begin
        glob_q[g] <= rf_global;
        size_q[g] <= rf_section ? SZ_SECTION : SZ_PAGE;
        asid_q[g] <= rf_asid;
        tag_q[g]  <= rf_vpn;
        pfn_q[g]  <= rf_pfn;
        attr_q[g] <= '{ap: rf_ap, cb: rf_cb, dom: rf_dom};
      end
    end
  end

  // R8: full flush empties the table
  a_r8_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> (valid_q == '0));
  // R9: selective flush keeps global entries
  a_r9_global_survive: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_asid_en && !fl_all) |=> ((valid_q & glob_q) == $past(valid_q & glob_q)));
  // R10: no entry becomes valid during a flush
  a_r10_flush_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> ((valid_q & ~$past(valid_q)) == '0));
  // R6: refill into a non-full table adds exactly one entry
  a_r6_fill_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !all_valid) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
  // R2: a hit always comes from a valid entry
  a_r2_hit_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q != '0));
  // R3: a lookup produces either a hit or a walk, never both
  a_r3_hit_xor_walk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != walk_req));
endmodule

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic [7:0]  cur_asid;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [1:0]  lk_ap, lk_cb;
  logic [3:0]  lk_dom;
  logic        walk_req;
  logic [31:0] walk_va;
  logic        rf_valid;
  logic [19:0] rf_vpn, rf_pfn;
  logic        rf_section, rf_global;
  logic [7:0]  rf_asid;
  logic [1:0]  rf_ap, rf_cb;
  logic [3:0]  rf_dom;
  logic        fl_all, fl_asid_en;
  logic [7:0]  fl_asid;

  always #5 clk = ~clk;

  asid_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .cur_asid(cur_asid),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_ap(lk_ap), .lk_cb(lk_cb), .lk_dom(lk_dom),
    .walk_req(walk_req), .walk_va(walk_va), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
    .rf_pfn(rf_pfn), .rf_section(rf_section), .rf_global(rf_global), .rf_asid(rf_asid),
    .rf_ap(rf_ap), .rf_cb(rf_cb), .rf_dom(rf_dom), .fl_all(fl_all),
    .fl_asid_en(fl_asid_en), .fl_asid(fl_asid)
  );

  // reference model
  logic        m_v   [N];
  logic        m_sec [N];
  logic        m_g   [N];
  logic [7:0]  m_as  [N];
  logic [19:0] m_tag [N];
  logic [19:0] m_pfn [N];
  logic [7:0]  m_att [N];
  int          m_rr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic logic [75:0] expect_out(logic v, logic [31:0] va, logic [7:0] as);
    logic [75:0] r;
    r = '0;
    if (!v) return r;
    for (int i = 0; i < N; i++) begin
      logic t;
      t = m_sec[i] ? (m_tag[i][19:8] == va[31:20]) : (m_tag[i] == va[31:12]);
      if (m_v[i] && t && (m_g[i] || m_as[i] == as)) begin
        logic [31:0] pa;
        pa = m_sec[i] ? {m_pfn[i][19:8], va[19:0]} : {m_pfn[i], va[11:0]};
        r = {1'b1, pa, m_att[i], 1'b0, 32'h0, 2'b00};
        return r;
      end
    end
    r = {1'b0, 32'h0, 8'h0, 1'b1, va, 2'b00};
    return r;
  endfunction

  task automatic model_update();
    if (fl_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (fl_asid_en) begin
      for (int i = 0; i < N; i++)
        if (!m_g[i] && m_as[i] == fl_asid) m_v[i] = 1'b0;
    end else if (rf_valid) begin
      int k;
      k = -1;
      for (int i = 0; i < N; i++)
        if (k < 0 && !m_v[i]) k = i;
      if (k < 0) begin
        k = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[k] = 1'b1; m_sec[k] = rf_section; m_g[k] = rf_global; m_as[k] = rf_asid;
      m_tag[k] = rf_vpn; m_pfn[k] = rf_pfn; m_att[k] = {rf_ap, rf_cb, rf_dom};
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_va = '0; cur_asid = '0;
    rf_valid = 0; rf_vpn = '0; rf_pfn = '0; rf_section = 0; rf_global = 0;
    rf_asid = '0; rf_ap = '0; rf_cb = '0; rf_dom = '0;
    fl_all = 0; fl_asid_en = 0; fl_asid = '0;
  endtask

  // one cycle: inputs already set; check lookup, then let the edge commit
  task automatic step(string req);
    logic [75:0] act, exp;
    #1;
    exp = expect_out(lk_valid, lk_va, cur_asid);
    act = {lk_hit, lk_pa, lk_ap, lk_cb, lk_dom, walk_req, walk_va, 2'b00};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (va %h asid %h)", req, act, exp, lk_va, cur_asid);
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic look(logic [31:0] va, logic [7:0] as, string req);
    lk_valid = 1; lk_va = va; cur_asid = as;
    step(req);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic sec, logic g,
                      logic [7:0] as, logic [7:0] att);
    rf_valid = 1; rf_vpn = vpn; rf_pfn = pfn; rf_section = sec; rf_global = g;
    rf_asid = as; {rf_ap, rf_cb, rf_dom} = att;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_sec[i] = 0; m_g[i] = 0; m_as[i] = 0;
      m_tag[i] = 0; m_pfn[i] = 0; m_att[i] = 0;
    end
    m_rr = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    look(32'h1234_5678, 8'd1, "R1");
    look(32'hC000_0000, 8'd0, "R1");
    // R3: no lookup, no walk, no hit
    lk_valid = 0; lk_va = 32'hDEAD_BEEF; step("R3");

    // R4/R2/R5: global section
    fill(20'hC01_23, 20'h801_FF, 1, 1, 8'd0, 8'hA5); step("R6");
    look(32'hC01F_FFFC, 8'd9, "R4");   // same section, other low bits
    look(32'hC012_3456, 8'd3, "R5");   // global, any asid
    look(32'hC02F_0000, 8'd3, "R4");   // neighbour section misses
    // R5: non-global page
    fill(20'h00400, 20'h12345, 0, 0, 8'd3, 8'h3C); step("R6");
    look(32'h0040_0ABC, 8'd3, "R2");
    look(32'h0040_0ABC, 8'd4, "R5");
    look(32'h0040_1ABC, 8'd3, "R4");   // next page misses
    // R11: overlapping entries, lowest index wins
    fill(20'h00400, 20'h55555, 0, 1, 8'd7, 8'h11); step("R11");
    look(32'h0040_0010, 8'd3, "R11");
    look(32'h0040_0010, 8'd4, "R11");

    // R6/R7: fill to full and beyond, probe evictions
    for (int i = 0; i < 12; i++) begin
      fill(20'h10000 + 20'(i), 20'h20000 + 20'(i), 0, 0, 8'd2, 8'(i)); step("R7");
      look({12'h100, 8'(i), 12'h004}, 8'd2, "R7");
      look(32'hC010_0000, 8'd2, "R7");
      look(32'h0040_0000, 8'd3, "R7");
    end

    // R9: selective flush of asid 2, then full table probe
    fl_asid_en = 1; fl_asid = 8'd2; step("R9");
    for (int i = 0; i < 12; i++) look({12'h100, 8'(i), 12'h0}, 8'd2, "R9");
    look(32'h0040_0000, 8'd3, "R9");
    // R10: flush with refill in same cycle
    fl_asid_en = 1; fl_asid = 8'd5;
    fill(20'h77777, 20'h00001, 0, 1, 8'd0, 8'h00); step("R10");
    look(32'h7777_7000, 8'd0, "R10");
    // R8: full flush
    fl_all = 1; step("R8");
    look(32'h0040_0000, 8'd3, "R8");
    look(32'hC010_0000, 8'd0, "R8");
    fl_all = 1; fill(20'h66666, 20'h00002, 1, 1, 8'd0, 8'h00); step("R10");
    look(32'h6660_0000, 8'd0, "R10");

    // random mix
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 100;
      lk_valid = ($urandom % 8) != 0;
      lk_va = {8'h40 + 8'($urandom % 6), 4'($urandom % 2), 8'($urandom % 3), 12'($urandom)};
      cur_asid = 8'(1 + $urandom % 3);
      if (r < 2) fl_all = 1;
      else if (r < 5) begin fl_asid_en = 1; fl_asid = 8'(1 + $urandom % 3); end
      if (r >= 3 && r < 40)
        fill({8'h40 + 8'($urandom % 6), 4'($urandom % 2), 8'($urandom % 3)},
             20'($urandom), 1'($urandom), (($urandom % 4) == 0),
             8'(1 + $urandom % 3), 8'($urandom));
      step("R2");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule